// File: doc/BRIEF.md
# Memory-Mapped Port I/O Bridge

This block sits between a processor's memory bus and a 16-bit port I/O space of the kind found on ISA-style peripherals. It watches every processor access. When the address falls inside a 64 KB window, it turns the access into exactly one port transaction of the same width (8, 16 or 32 bits). The port address is the low 16 bits of the processor address. Accesses outside the window never reach the port side. They still complete, so the processor does not stall on them.

A `big_endian` input selects the processor's byte order, and it is sampled when the bridge accepts a request. In big-endian mode the bridge byte-reverses halfword and word data in both directions. Byte data always passes through unchanged. In little-endian mode no data is rearranged. Read data narrower than 32 bits is returned zero-extended.

The processor raises `cpu_rd` or `cpu_wr` and holds the address, size and data until `cpu_ready` pulses. The bridge drives its port strobe until the device answers with `io_ack`.

Top module: `isa_io_bridge`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `cpu_ready`, `io_rd` and `io_wr` are low and `cpu_rdata` is zero.
- R2: An access whose address bits [31:16] are not 0x7000 raises neither `io_rd` nor `io_wr`. It completes with `cpu_ready` high in the cycle after the request is sampled, and its read data is zero.
- R3: For an access inside the window, `io_addr` equals `cpu_addr[15:0]`. `io_width` follows `cpu_size` (0 = byte, 1 = halfword, 2 = word), and size code 3 is treated as a word with `io_width` = 2.
- R4: An in-window access raises exactly one port strobe (`io_wr` for a write, `io_rd` for a read) in the cycle after the request is sampled. The strobe, `io_addr`, `io_width` and `io_wdata` hold steady until `io_ack` is sampled high. The strobe is low in the following cycle. `io_rd` and `io_wr` are never high together.
- R5: `cpu_ready` goes high for exactly one cycle, in the cycle after `io_ack` is sampled, and `cpu_rdata` carries the read result in that cycle.
- R6: Byte accesses are never swapped. Write data bits [7:0] appear on `io_wdata[7:0]` with the upper bits zero. Read data `io_rdata[7:0]` returns on `cpu_rdata[7:0]` with the upper bits zero.
- R7: With `big_endian` = 1, a halfword has its two bytes exchanged on both the write path and the read path, and bits [31:16] are zero.
- R8: With `big_endian` = 1, a word has byte 0 exchanged with byte 3 and byte 1 exchanged with byte 2, in both directions.
- R9: With `big_endian` = 0, halfword and word data pass unchanged in both directions, with halfword bits [31:16] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | Processor byte order, sampled when a request is accepted |
| cpu_addr | input | 32 | Processor physical address |
| cpu_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| cpu_rd | input | 1 | Read request, held until ready |
| cpu_wr | input | 1 | Write request, held until ready |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_rdata | output | 32 | Read data, zero-extended, valid with ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| io_addr | output | 16 | Port address |
| io_width | output | 2 | Port access width: 0 byte, 1 halfword, 2 word |
| io_wdata | output | 32 | Port write data, after lane ordering |
| io_rd | output | 1 | Port read strobe, held until acknowledge |
| io_wr | output | 1 | Port write strobe, held until acknowledge |
| io_rdata | input | 32 | Port read data, sampled with acknowledge |
| io_ack | input | 1 | Port acknowledge |

## Verification
The properties assume that the processor never raises `cpu_rd` and `cpu_wr` together. They also assume it keeps its request steady until `cpu_ready` and drops it in the cycle that `cpu_ready` is seen. Finally, they assume `io_ack` arrives only while a port strobe is up. The bench drives a single access at a time from a task that follows those rules. It raises `io_ack` only after a chosen number of strobe cycles, and it releases the request as soon as completion is observed. Device latency, byte order, size and the window edges are varied across the accesses.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } br_state_t;
endpackage

// File: rtl/isa_win_decode.sv
module isa_win_decode #(
  parameter int          ADDR_W   = 32,
  parameter int          PORT_W   = 16,
  parameter logic [31:0] WIN_BASE = 32'h7000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [PORT_W-1:0] port
);
  localparam int TAG_W = ADDR_W - PORT_W;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:PORT_W];

  assign hit  = (addr[ADDR_W-1:PORT_W] == WIN_TAG);
  assign port = addr[PORT_W-1:0];
endmodule

// File: rtl/isa_lane_swap.sv
module isa_lane_swap #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        size,
  input  logic              be,
  output logic [DATA_W-1:0] dout
);
  import isa_bridge_pkg::*;
  localparam int NL = DATA_W / 8;

  logic [DATA_W-1:0] rev;

  genvar g;
  generate
    for (g = 0; g < NL; g++) begin : g_lane
      assign rev[g*8 +: 8] = din[(NL-1-g)*8 +: 8];
    end
  endgenerate

  always_comb begin
    dout = '0;
    case (acc_size_t'(size))
      SZ_BYTE: dout[7:0]  = din[7:0];
      SZ_HALF: dout[15:0] = be ? {din[7:0], din[15:8]} : din[15:0];
      default: dout       = be ? rev : din;
    endcase
  end
endmodule

// File: rtl/isa_io_bridge.sv
module isa_io_bridge #(
  parameter int          ADDR_W   = 32,
  parameter int          PORT_W   = 16,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] WIN_BASE = 32'h7000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_endian,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic [PORT_W-1:0] io_addr,
  output logic [1:0]        io_width,
  output logic [DATA_W-1:0] io_wdata,
  output logic              io_rd,
  output logic              io_wr,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic              io_ack
);
  import isa_bridge_pkg::*;

  br_state_t         state;
  logic              be_q;
  logic              wr_q;
  logic [1:0]        size_q;
  logic              win_hit;
  logic [PORT_W-1:0] win_port;
  logic [DATA_W-1:0] wr_lanes;
  logic [DATA_W-1:0] rd_lanes;
  logic [1:0]        width_norm;

  isa_win_decode #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .WIN_BASE(WIN_BASE)) u_dec (
    .addr(cpu_addr), .hit(win_hit), .port(win_port)
  );

  isa_lane_swap #(.DATA_W(DATA_W)) u_wswap (
    .din(cpu_wdata), .size(cpu_size), .be(big_endian), .dout(wr_lanes)
  );

  isa_lane_swap #(.DATA_W(DATA_W)) u_rswap (
    .din(io_rdata), .size(size_q), .be(be_q), .dout(rd_lanes)
  );

  assign width_norm = (cpu_size == SZ_WIDE) ? SZ_WORD : cpu_size;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      be_q      <= 1'b0;
      wr_q      <= 1'b0;
      size_q    <= SZ_BYTE;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      io_addr   <= '0;
      io_width  <= SZ_BYTE;
      io_wdata  <= '0;
      io_rd     <= 1'b0;
      io_wr     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cpu_rd || cpu_wr) begin
            be_q   <= big_endian;
            wr_q   <= cpu_wr;
            size_q <= cpu_size;
            if (win_hit) begin
              io_addr  <= win_port;
              io_width <= width_norm;
              io_wdata <= cpu_wr ? wr_lanes : '0;
              io_rd    <= ~cpu_wr;
              io_wr    <= cpu_wr;
              state    <= ST_BUSY;
            end else begin
              cpu_ready <= 1'b1;
              cpu_rdata <= '0;
              state     <= ST_DONE;
            end
          end
        end
        ST_BUSY: begin
          if (io_ack) begin
            io_rd     <= 1'b0;
            io_wr     <= 1'b0;
            cpu_ready <= 1'b1;
            cpu_rdata <= wr_q ? '0 : rd_lanes;
            state     <= ST_DONE;
          end
        end
        default: begin
          cpu_ready <= 1'b0;
          state     <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/isa_io_bridge_chk.sv
module isa_io_bridge_chk #(
  parameter int          ADDR_W   = 32,
  parameter int          PORT_W   = 16,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] WIN_BASE = 32'h7000_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic [PORT_W-1:0] io_addr,
  input logic [1:0]        io_width,
  input logic [DATA_W-1:0] io_wdata,
  input logic              io_rd,
  input logic              io_wr,
  input logic              io_ack
);
  localparam logic [ADDR_W-PORT_W-1:0] TAG = WIN_BASE[ADDR_W-1:PORT_W];

  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && io_wr));

  a_r4_strobe_hold: assert property (@(posedge clk) disable iff (rst)
    ((io_rd || io_wr) && !io_ack) |=> ((io_rd || io_wr) && $stable(io_rd) && $stable(io_wr)));

  a_r4_port_stable: assert property (@(posedge clk) disable iff (rst)
    ((io_rd || io_wr) && !io_ack) |=> ($stable(io_addr) && $stable(io_width) && $stable(io_wdata)));

  a_r4_strobe_drop: assert property (@(posedge clk) disable iff (rst)
    ((io_rd || io_wr) && io_ack) |=> (!io_rd && !io_wr));

  a_r5_ready_after_ack: assert property (@(posedge clk) disable iff (rst)
    ((io_rd || io_wr) && io_ack) |=> cpu_ready);

  a_r5_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  a_r5_no_ready_while_busy: assert property (@(posedge clk) disable iff (rst)
    (io_rd || io_wr) |-> !cpu_ready);

  a_r2_window_only: assert property (@(posedge clk) disable iff (rst)
    $rose(io_rd || io_wr) |-> ($past(cpu_addr[ADDR_W-1:PORT_W]) == TAG));

  a_r3_width_legal: assert property (@(posedge clk) disable iff (rst)
    (io_rd || io_wr) |-> (io_width != 2'd3));
endmodule

bind isa_io_bridge isa_io_bridge_chk #(
  .ADDR_W(ADDR_W), .PORT_W(PORT_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE)
) u_chk (.*);

// File: tb/sim_isa_io_bridge.sv
`timescale 1ns/1ps
module sim_isa_io_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        big_endian;
  logic [31:0] cpu_addr;
  logic [1:0]  cpu_size;
  logic        cpu_rd, cpu_wr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_ready;
  logic [15:0] io_addr;
  logic [1:0]  io_width;
  logic [31:0] io_wdata, io_rdata;
  logic        io_rd, io_wr, io_ack;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_io_bridge u0 (
    .clk(clk), .rst(rst), .big_endian(big_endian),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .io_addr(io_addr), .io_width(io_width), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata), .io_ack(io_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_order(input logic [31:0] d, input logic [1:0] sz, input logic be);
    int n;
    logic [31:0] r;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    r = '0;
    for (int i = 0; i < n; i++)
      r[i*8 +: 8] = (be && n > 1) ? d[(n-1-i)*8 +: 8] : d[i*8 +: 8];
    return r;
  endfunction

  function automatic string dtag(input logic [1:0] sz, input logic be);
    if (sz == 2'd0) return "R6";
    if (!be) return "R9";
    if (sz == 2'd1) return "R7";
    return "R8";
  endfunction

  task automatic access(input bit wr, input logic [31:0] addr, input logic [1:0] sz,
                        input logic be, input logic [31:0] wd, input logic [31:0] dev,
                        input int lat);
    bit hit;
    logic [1:0]  ew;
    logic [31:0] ewd, erd;
    hit = (addr[31:16] == 16'h7000);
    ew  = (sz == 2'd3) ? 2'd2 : sz;
    ewd = wr ? ref_order(wd, sz, be) : 32'h0;
    erd = wr ? 32'h0 : ref_order(dev, sz, be);
    @(negedge clk);
    cpu_addr = addr; cpu_size = sz; big_endian = be; cpu_wdata = wd;
    cpu_rd = !wr; cpu_wr = wr;
    @(negedge clk);
    if (hit) begin
      for (int i = 0; i < lat; i++) begin
        chk("R4 strobes", {30'b0, io_rd, io_wr}, {30'b0, !wr, wr});
        chk("R5 ready low while waiting", {31'b0, cpu_ready}, 32'h0);
        chk("R3 port address", {16'b0, io_addr}, {16'b0, addr[15:0]});
        chk("R3 port width", {30'b0, io_width}, {30'b0, ew});
        chk({dtag(sz, be), " write lanes"}, io_wdata, ewd);
        if (i == lat - 1) begin
          io_ack = 1'b1;
          io_rdata = dev;
        end
        @(negedge clk);
      end
      io_ack = 1'b0;
      io_rdata = 32'hDEAD_BEEF;
      chk("R4 strobes dropped", {30'b0, io_rd, io_wr}, 32'h0);
      chk("R5 ready pulse", {31'b0, cpu_ready}, 32'h1);
      if (!wr) chk({dtag(sz, be), " read lanes"}, cpu_rdata, erd);
    end else begin
      chk("R2 no strobe outside window", {30'b0, io_rd, io_wr}, 32'h0);
      chk("R2 ready outside window", {31'b0, cpu_ready}, 32'h1);
      chk("R2 read data zero", cpu_rdata, 32'h0);
    end
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    @(negedge clk);
    chk("R5 ready one cycle", {31'b0, cpu_ready}, 32'h0);
    chk("R4 idle strobes", {30'b0, io_rd, io_wr}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; big_endian = 1'b0; cpu_addr = '0; cpu_size = '0;
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0; io_rdata = '0; io_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'b0, cpu_ready}, 32'h0);
    chk("R1 strobes in reset", {30'b0, io_rd, io_wr}, 32'h0);
    chk("R1 rdata in reset", cpu_rdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", {31'b0, cpu_ready}, 32'h0);

    // byte accesses, both orders (R6)
    access(1, 32'h7000_03F8, 2'd0, 1, 32'h1234_56A5, 32'h0, 1);
    access(0, 32'h7000_03FD, 2'd0, 1, 32'h0, 32'hAABB_CCDD, 2);
    access(0, 32'h7000_0060, 2'd0, 0, 32'h0, 32'h1122_3344, 1);
    // halfword (R7, R9)
    access(1, 32'h7000_01F0, 2'd1, 1, 32'hFFFF_1234, 32'h0, 3);
    access(0, 32'h7000_01F0, 2'd1, 1, 32'h0, 32'h9999_ABCD, 1);
    access(1, 32'h7000_0170, 2'd1, 0, 32'h5555_BEEF, 32'h0, 2);
    access(0, 32'h7000_0172, 2'd1, 0, 32'h0, 32'h7777_C0DE, 4);
    // word (R8, R9), size 3 as word (R3)
    access(1, 32'h7000_0CF8, 2'd2, 1, 32'h0102_0304, 32'h0, 2);
    access(0, 32'h7000_0CFC, 2'd2, 1, 32'h0, 32'hA1B2_C3D4, 1);
    access(1, 32'h7000_0CF8, 2'd2, 0, 32'h8000_0001, 32'h0, 1);
    access(0, 32'h7000_0CFC, 2'd3, 0, 32'h0, 32'hCAFE_F00D, 3);
    access(0, 32'h7000_FFFC, 2'd3, 1, 32'h0, 32'h1357_9BDF, 2);
    // window edges (R2, R3)
    access(1, 32'h7000_0000, 2'd0, 0, 32'h0000_00FF, 32'h0, 1);
    access(0, 32'h7000_FFFF, 2'd0, 1, 32'h0, 32'h0000_0042, 1);
    access(1, 32'h7001_0000, 2'd2, 1, 32'h1111_2222, 32'h0, 1);
    access(0, 32'h6FFF_FFFF, 2'd1, 0, 32'h0, 32'h3333_4444, 1);
    access(0, 32'h0000_03F8, 2'd0, 0, 32'h0, 32'h5555_6666, 1);
    // back to in-window after a miss
    access(0, 32'h7000_0064, 2'd1, 1, 32'h0, 32'h0000_0102, 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule